// File: doc/BRIEF.md
# Burst DRAM Refresh Controller

This block keeps a bank of dynamic RAM alive by refreshing every row once per refresh period, all in a single uninterrupted burst. A free-running period timer expires once per period. At each expiry the controller raises a bus request towards the system arbiter and waits for a grant. Once granted, it owns the DRAM for the whole burst. It walks a row counter from zero to the last row, and for each row it drives the row onto the multiplexed address lines and pulses the row strobe low. The column strobe stays inactive throughout, so every cycle is a row-strobe-only refresh.

The burst runs on the controller's own clock and not at the pace of the processor bus. Each refresh cycle therefore lasts exactly the programmed strobe-low time plus the precharge time, counted in controller cycles. With the default settings (8 MHz controller clock, 2 + 1 cycles per row, 128 rows) one row takes 375 ns, the whole burst takes 48 µs, and the period is 2 ms. The request is dropped one cycle after the precharge of the last row, which hands the bus back to other masters. If a period expires while the grant is still outstanding, the controller raises a one-cycle overrun flag and keeps waiting.

The sequencer has five states. IDLE waits for the period tick and moves to REQ on it. REQ holds the request; a grant moves it to STROBE and clears the row counter, and a tick seen while still in REQ raises overrun. STROBE holds the row strobe low and moves to PRECHARGE when its count ends. PRECHARGE holds the strobe high; when its count ends it returns to STROBE with the next row, or goes to RELEASE after the last row. RELEASE lasts one cycle and returns to IDLE.

Top module: `burst_refresh_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, bus_req=0, busy=0, ras_n=1, cas_n=1, overrun=0 and row_addr=0.
- R2: The period timer runs from the release of reset. bus_req rises only on controller cycles that are a whole multiple of PERIOD_CYC after reset, the first one exactly PERIOD_CYC cycles after reset, as long as the controller is idle when the period expires.
- R3: No row strobe is issued without a grant. The first ras_n low of a burst appears exactly one cycle after the first cycle in which bus_grant is sampled high with bus_req high.
- R4: Each burst issues exactly 2**ROW_W row strobes, with row_addr taking the values 0, 1, …, 2**ROW_W-1 in ascending order. Every burst starts again from row 0.
- R5: Each ras_n low pulse lasts exactly RAS_LOW_CYC cycles. Between two strobes of the same burst, ras_n stays high for exactly PRECHG_CYC cycles.
- R6: cas_n is 1 in every cycle.
- R7: bus_req falls exactly PRECHG_CYC+1 cycles after ras_n rises at the end of the last row, which is one cycle after the final precharge.
- R8: When the period expires while bus_req is high and no grant has yet been taken, overrun is high for that one cycle. The request stays up, and one overrun pulse occurs per expired period.
- R9: busy rises in the same cycle as the first strobe of a burst, falls in the same cycle as bus_req, and is never high without bus_req.
- R10: row_addr is 0 whenever bus_req is low, and it does not change while ras_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all burst timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | Grant from the arbiter; the bus belongs to this block while it is high |
| bus_req | output | 1 | Request for the DRAM bus, held from the period expiry until the burst ends |
| busy | output | 1 | High while the burst owns the DRAM |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe, held inactive |
| row_addr | output | ROW_W | Row address for the multiplexed address lines |
| overrun | output | 1 | One-cycle flag: a period expired while the grant was still pending |

## Verification
The bench sweeps the grant latency over zero, short, odd and long values. At every latency it checks that the first strobe lands exactly one cycle after the grant. A design that sampled the grant late, or strobed before the grant arrived, would shift that edge or strobe on a bus it does not own. The widths of every strobe and precharge, the exact row sequence, and the restart at row 0 are measured on every burst. An off-by-one in the phase counters or in the last-row detection would show up as a wrong pulse length, a missing or extra row, or a burst that resumes at the wrapped row. A grant held back across two period expiries must yield exactly two overrun pulses, each on the expiry cycle, and then a normal burst. The release timing is also checked against the final precharge, because a request dropped early would hand the bus back mid-cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_STROBE,
        ST_PRECHARGE,
        ST_RELEASE
    } brc_state_e;

endpackage

// File: rtl/brc_period_timer.sv
module brc_period_timer #(
    parameter int PERIOD_CYC = 16000
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_tick
);
    localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign period_tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/brc_row_counter.sv
module brc_row_counter #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [ROW_W-1:0] row,
    output logic             row_last
);
    localparam logic [ROW_W-1:0] TOP_ROW = '1;

    logic [ROW_W-1:0] row_q;

    assign row      = row_q;
    assign row_last = (row_q == TOP_ROW);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            row_q <= '0;
        end else if (advance) begin
            row_q <= row_q + 1'b1;
        end
    end
endmodule

// File: rtl/brc_strobe_seq.sv
module brc_strobe_seq
    import brc_pkg::*;
#(
    parameter int RAS_LOW_CYC = 2,
    parameter int PRECHG_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_tick,
    input  logic bus_grant,
    input  logic row_last,
    output logic row_clear,
    output logic row_advance,
    output logic bus_req,
    output logic busy,
    output logic ras_n,
    output logic overrun,
    output logic addr_en
);
    localparam int PH_MAX = (RAS_LOW_CYC > PRECHG_CYC) ? RAS_LOW_CYC : PRECHG_CYC;
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam logic [PH_W-1:0] STROBE_END = PH_W'(RAS_LOW_CYC - 1);
    localparam logic [PH_W-1:0] PRECH_END  = PH_W'(PRECHG_CYC - 1);

    brc_state_e state_q, state_d;
    logic [PH_W-1:0] ph_q;
    logic strobe_done, prech_done;

    assign strobe_done = (ph_q == STROBE_END);
    assign prech_done  = (ph_q == PRECH_END);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (period_tick) state_d = ST_REQ;
            ST_REQ:       if (bus_grant) state_d = ST_STROBE;
            ST_STROBE:    if (strobe_done) state_d = ST_PRECHARGE;
            ST_PRECHARGE: if (prech_done) state_d = row_last ? ST_RELEASE : ST_STROBE;
            ST_RELEASE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // phase counter, restarted on every state change
    always_ff @(posedge clk) begin
        if (!rst_n || state_d != state_q) begin
            ph_q <= '0;
        end else if (state_q == ST_STROBE || state_q == ST_PRECHARGE) begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_req     = 1'b0;
        busy        = 1'b0;
        ras_n       = 1'b1;
        overrun     = 1'b0;
        addr_en     = 1'b0;
        row_clear   = 1'b0;
        row_advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_REQ: begin
                bus_req   = 1'b1;
                overrun   = period_tick;
                row_clear = bus_grant;
            end
            ST_STROBE: begin
                bus_req = 1'b1;
                busy    = 1'b1;
                ras_n   = 1'b0;
                addr_en = 1'b1;
            end
            ST_PRECHARGE: begin
                bus_req     = 1'b1;
                busy        = 1'b1;
                addr_en     = 1'b1;
                row_advance = prech_done && !row_last;
            end
            ST_RELEASE: begin
                bus_req = 1'b1;
                busy    = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/burst_refresh_ctrl.sv
module burst_refresh_ctrl #(
    parameter int ROW_W       = 7,
    parameter int RAS_LOW_CYC = 2,
    parameter int PRECHG_CYC  = 1,
    parameter int PERIOD_CYC  = 16000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_grant,
    output logic             bus_req,
    output logic             busy,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             overrun
);
    logic             period_tick;
    logic             row_clear, row_advance, row_last, addr_en;
    logic [ROW_W-1:0] row_val;

    brc_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick)
    );

    brc_row_counter #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (row_clear),
        .advance  (row_advance),
        .row      (row_val),
        .row_last (row_last)
    );

    brc_strobe_seq #(
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .PRECHG_CYC  (PRECHG_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_tick (period_tick),
        .bus_grant   (bus_grant),
        .row_last    (row_last),
        .row_clear   (row_clear),
        .row_advance (row_advance),
        .bus_req     (bus_req),
        .busy        (busy),
        .ras_n       (ras_n),
        .overrun     (overrun),
        .addr_en     (addr_en)
    );

    assign cas_n    = 1'b1;
    assign row_addr = addr_en ? row_val : '0;
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int ROW_W       = 7,
    parameter int RAS_LOW_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_grant,
    input logic             bus_req,
    input logic             busy,
    input logic             ras_n,
    input logic [ROW_W-1:0] row_addr,
    input logic             overrun
);
    logic        ras_q;
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q   <= 1'b1;
            low_cnt <= '0;
        end else begin
            ras_q   <= ras_n;
            low_cnt <= ras_n ? 16'd0 : low_cnt + 16'd1;
        end
    end

    // R3
    ras_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (bus_req && bus_grant));

    // R5
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !ras_q) |-> (low_cnt == 16'(RAS_LOW_CYC)));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !ras_q) |-> $stable(row_addr));

    // R10
    idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (row_addr == '0));

    // R8
    overrun_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (bus_req && !busy && ras_n));

    // R9
    busy_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_req);
endmodule

bind burst_refresh_ctrl brc_checker #(
    .ROW_W       (ROW_W),
    .RAS_LOW_CYC (RAS_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_grant (bus_grant),
    .bus_req   (bus_req),
    .busy      (busy),
    .ras_n     (ras_n),
    .row_addr  (row_addr),
    .overrun   (overrun)
);

// File: tb/tb_burst_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_burst_refresh_ctrl;
    localparam int ROW_W = 4;
    localparam int RASL  = 3;
    localparam int PRE   = 2;
    localparam int PER   = 200;
    localparam int ROWS  = 1 << ROW_W;
    localparam int NRUNS = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_grant = 1'b0;
    logic             bus_req, busy, ras_n, cas_n, overrun;
    logic [ROW_W-1:0] row_addr;

    always #4 clk = ~clk;

    burst_refresh_ctrl #(
        .ROW_W(ROW_W), .RAS_LOW_CYC(RASL), .PRECHG_CYC(PRE), .PERIOD_CYC(PER)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
        .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
        .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cur_delay = 0;
    int bursts = 0;
    int overruns = 0;
    int exp_row = 0;
    int req_rise_cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = 0;
    int first_rise = 1;
    int cas_bad = 0;
    logic prev_req = 1'b0, prev_ras = 1'b1, prev_busy = 1'b0;
    logic finished = 1'b0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!cas_n) cas_bad++;
            // R2: request timing
            if (bus_req && !prev_req) begin
                req_rise_cyc = cyc;
                check(cyc % PER == 0, "R2 request on period boundary", cyc % PER, 0);
                if (first_rise == 1) check(cyc == PER, "R2 first request", cyc, PER);
                first_rise = 0;
                exp_row = 0;
            end
            if (!ras_n && prev_ras) begin
                check(bus_req && bus_grant, "R3 strobe only when granted", bus_grant, 1);
                check(int'(row_addr) == exp_row, "R4 row sequence", row_addr, exp_row);
                if (exp_row == 0) begin
                    check(cyc - req_rise_cyc == cur_delay + 1, "R3 first strobe after grant",
                          cyc - req_rise_cyc, cur_delay + 1);
                    check(busy && !prev_busy, "R9 busy rises with first strobe", busy, 1);
                end else begin
                    check(cyc - ras_rise_cyc == PRE, "R5 precharge width",
                          cyc - ras_rise_cyc, PRE);
                end
                ras_fall_cyc = cyc;
                exp_row++;
            end
            if (ras_n && !prev_ras) begin
                check(cyc - ras_fall_cyc == RASL, "R5 strobe width", cyc - ras_fall_cyc, RASL);
                ras_rise_cyc = cyc;
            end
            if (!bus_req && prev_req) begin
                bursts++;
                check(exp_row == ROWS, "R4 strobes per burst", exp_row, ROWS);
                check(cyc - ras_rise_cyc == PRE + 1, "R7 release after last precharge",
                      cyc - ras_rise_cyc, PRE + 1);
                check(!busy, "R9 busy falls with request", busy, 0);
                check(cas_bad == 0, "R6 column strobe inactive", cas_bad, 0);
            end
            if (overrun) begin
                overruns++;
                check(bus_req && !busy && (cyc % PER == PER - 1), "R8 overrun on expiry",
                      cyc % PER, PER - 1);
            end
            if (busy && !bus_req) check(1'b0, "R9 busy without request", busy, 0);
            prev_req  = bus_req;
            prev_ras  = ras_n;
            prev_busy = busy;
        end
    end

    // grant responder sweeping latencies
    initial begin
        int delays [NRUNS];
        delays = '{0, 1, 3, 7, 2 * PER + 5, 0};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!bus_req && !busy && ras_n && cas_n && !overrun && row_addr == 0,
              "R1 outputs in reset", {bus_req, busy, ras_n, cas_n, overrun}, 5'b00110);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !busy && ras_n && cas_n && !overrun && row_addr == 0,
              "R1 outputs after reset", {bus_req, busy, ras_n, cas_n, overrun}, 5'b00110);
        for (int i = 0; i < NRUNS; i++) begin
            cur_delay = delays[i];
            while (!bus_req) @(negedge clk);
            repeat (cur_delay) @(negedge clk);
            bus_grant = 1'b1;
            while (bus_req) @(negedge clk);
            bus_grant = 1'b0;
        end
        repeat (5) @(negedge clk);
        finished = 1'b1;
        check(bursts == NRUNS, "R4 burst count", bursts, NRUNS);
        check(overruns == 2, "R8 overrun count", overruns, 2);
        check(row_addr == 0 && !bus_req, "R10 idle address", row_addr, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d bursts", bursts, NRUNS);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule